// File: doc/BRIEF.md
# SPI Memory Write-Protect Status Register

This block holds the protection state of a 4K-byte serial memory that sits behind an SPI slave port (mode 0). It watches the SPI chip-select, clock and data-in lines and acts on three instructions. Two one-byte instructions set and clear a write-enable latch. A two-byte instruction writes the status register. The status write only takes effect if the latch was set beforehand, and only when chip-select rises after exactly sixteen clocks. It updates a hardware-lock enable bit and two block-protect bits. The data-out line is never driven.

The block-protect bits split the 12-bit address space into four quarters. They lock none of them, the top quarter, the top half, or all of it. A combinational output tells the array write path whether the address on the request port falls in the locked range. An active-low protect pin, together with the lock-enable bit, freezes the three nonvolatile status bits. While frozen, status writes still run to completion and still clear the latch, but those three bits keep their values. The nonvolatile programming delay is reduced to a single register update.

All SPI inputs are assumed to be synchronous to the system clock. The SPI clock is sampled by that clock and must stay high and low for at least one system clock each.

Top module: `spi_wp_status`

## Requirements
- R1: An 8-clock frame carrying 0000_0110 sets the write-enable latch (status bit 1). An 8-clock frame carrying 0000_0100 clears it.
- R2: A 16-clock frame carries opcode 0000_0001 followed by a data byte, both sent MSB first. With the latch set, this frame loads data bit 7 into status bit 7 (lock enable) and data bits 3:2 into status bits 3:2 (block protect). Data bits 6:4 and 1:0 are ignored.
- R3: A status-write frame sent while the latch is clear leaves the status byte unchanged.
- R4: A frame that ends with 15 or 17 clocks leaves the status byte unchanged, and the latch keeps its value.
- R5: The latch clears when a complete status-write frame ends with the latch set. This holds whether or not the bits were frozen.
- R6: The hardware lock is active exactly when the protect pin is low and status bit 7 is 1. While it is active, a status write leaves bits 7 and 3:2 unchanged.
- R7: The address-locked output depends on block protect as follows:
  - 00: never set.
  - 01: set for addresses 0xC00 to 0xFFF.
  - 10: set for addresses 0x800 to 0xFFF.
  - 11: set for every address.
- R8: The data-out enable stays low at all times, and status bit 0 (write in progress) always reads 0.
- R9: After reset the status byte is 0x00. This covers reset applied in mid-run.
- R10: SPI clock edges while chip-select is high are ignored, and the clock count restarts with each new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_sck | input | 1 | SPI clock, data sampled on its rising edge |
| spi_mosi | input | 1 | SPI serial data in |
| spi_miso | output | 1 | SPI serial data out (held at 0) |
| spi_miso_oe | output | 1 | Data-out drive enable (always low: high-impedance) |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| addr | input | 12 | Array address offered by the write path |
| addr_locked | output | 1 | High when addr lies in the block-protected range |
| hw_lock | output | 1 | High while the hardware lock freezes the nonvolatile bits |
| status | output | 8 | Status byte: bit 7 lock enable, bits 3:2 block protect, bit 1 latch, bit 0 busy |

## Verification
The bench sends frames one clock short and one clock long. A design that committed on the opcode alone, or counted clocks loosely, would change the protect bits on these frames or drop the latch. It sends a status write while the pin is low and the lock enable is set. A design that froze the latch with the other bits, or ignored the pin, would show the wrong latch or protect value afterwards. It sweeps addresses just below and at each quarter boundary under every block-protect code, where an off-by-one segment compare shows up at 0x7FF/0x800 or 0xBFF/0xC00. It also toggles the SPI clock with chip-select high before a frame, so a counter that is not cleared would misread that frame.

// File: rtl/spi_wp_pkg.sv
// Package: shared constants of the SPI write-protect status block.
// Assumes MSB-first opcodes and the status bit layout listed in the brief.
package spi_wp_pkg;
    localparam logic [7:0] OP_SET_WEL   = 8'b0000_0110;
    localparam logic [7:0] OP_CLR_WEL   = 8'b0000_0100;
    localparam logic [7:0] OP_WR_STATUS = 8'b0000_0001;

    localparam int unsigned BIT_LOCK_EN = 7;
    localparam int unsigned BIT_BP_HI   = 3;
    localparam int unsigned BIT_BP_LO   = 2;
    localparam int unsigned BIT_WEL     = 1;
    localparam int unsigned BIT_BUSY    = 0;

    // Bits of the status byte that a status write may change.
    localparam logic [7:0] NV_MASK = 8'b1000_1100;
endpackage

// File: rtl/spi_wp_shifter.sv
// Module: SPI mode-0 frame collector.
// Samples the SPI clock and data with the system clock and counts rising
// edges while chip-select is low. It keeps the last FRAME_W bits and
// reports a one-cycle frame end when chip-select rises.
// Assumes the SPI inputs are synchronous to clk and that each SPI clock
// phase lasts at least one clk period.
module spi_wp_shifter #(
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               mosi,
    output logic               frame_end,
    output logic [CNT_W-1:0]   frame_cnt,
    output logic [FRAME_W-1:0] frame_bits
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic               sck_q;
    logic               cs_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic               sck_rise;

    // Purpose: rising SPI clock edge inside a frame.
    assign sck_rise  = sck & ~sck_q & ~cs_n;
    // Purpose: frame boundary on chip-select rising.
    assign frame_end = cs_n & ~cs_q;
    assign frame_cnt = cnt_q;
    assign frame_bits = sh_q;

    // Purpose: edge history, saturating clock count and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                cnt_q <= '0;
            end else if (sck_rise && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (sck_rise) begin
                sh_q <= {sh_q[FRAME_W-2:0], mosi};
            end
        end
    end

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/spi_wp_cmd.sv
// Module: instruction decoder and status register.
// Acts on completed frames. Eight-clock frames set or clear the write-enable
// latch. A sixteen-clock status write loads the nonvolatile bits if the
// latch is set and the hardware lock is off, and then clears the latch.
// Assumes frame_cnt and frame_bits are valid in the cycle frame_end is high.
module spi_wp_cmd
    import spi_wp_pkg::*;
#(
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_end,
    input  logic [CNT_W-1:0]   frame_cnt,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               wp_n,
    output logic [1:0]         bp,
    output logic               hw_lock,
    output logic [7:0]         status
);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(8);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);

    logic [7:0] nv_q;
    logic       wel_q;
    logic       do_set;
    logic       do_clr;
    logic       do_wrsr;
    logic [7:0] wr_data;

    // Purpose: classify the frame that just ended.
    always_comb begin
        do_set  = frame_end && frame_cnt == LEN_SHORT && frame_bits[7:0] == OP_SET_WEL;
        do_clr  = frame_end && frame_cnt == LEN_SHORT && frame_bits[7:0] == OP_CLR_WEL;
        do_wrsr = frame_end && frame_cnt == LEN_LONG && wel_q
                  && frame_bits[FRAME_W-1 -: 8] == OP_WR_STATUS;
        wr_data = frame_bits[7:0] & NV_MASK;
    end

    // Purpose: hardware lock from the pin and the lock-enable bit.
    assign hw_lock = ~wp_n & nv_q[BIT_LOCK_EN];
    assign bp      = nv_q[BIT_BP_HI:BIT_BP_LO];

    // Purpose: update the nonvolatile bits and the write-enable latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_q  <= '0;
            wel_q <= 1'b0;
        end else if (do_wrsr) begin
            if (!hw_lock) begin
                nv_q <= wr_data;
            end
            wel_q <= 1'b0;
        end else if (do_set) begin
            wel_q <= 1'b1;
        end else if (do_clr) begin
            wel_q <= 1'b0;
        end
    end

    // Purpose: assemble the status byte; the busy bit is always clear.
    always_comb begin
        status           = nv_q;
        status[BIT_WEL]  = wel_q;
        status[BIT_BUSY] = 1'b0;
    end

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hw_lock)) |-> $stable(nv_q)); // R6
    AST_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(nv_q)) |-> $past(wel_q)); // R3
    AST_EXACT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(nv_q)) |-> ($past(frame_cnt) == LEN_LONG)); // R4
    AST_WEL_FALLS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(wel_q)) |-> $past(frame_end)); // R5
endmodule

// File: rtl/spi_wp_range.sv
// Module: block-protect address comparator.
// Splits the address space into NSEG equal segments. The block-protect code
// picks how many top segments are locked: 0, 1, 2 or all. The output is
// combinational.
// Assumes NSEG is 4, which the two-bit block-protect code requires.
module spi_wp_range #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NSEG   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int unsigned SEG_SIZE = (1 << ADDR_W) / NSEG;
    localparam int unsigned NW       = $clog2(NSEG) + 2;

    logic [NW-1:0]   nlock;
    logic [NSEG-1:0] above;
    logic [NSEG-1:0] seg_lock;

    // Purpose: number of locked top segments for each code.
    always_comb begin
        case (bp)
            2'b00:   nlock = '0;
            2'b01:   nlock = NW'(1);
            2'b10:   nlock = NW'(2);
            default: nlock = NW'(NSEG);
        endcase
    end

    // Purpose: per-segment base compare and lock mask.
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        if (s == 0) begin : g_first
            assign above[s] = 1'b1;
        end else begin : g_rest
            assign above[s] = addr >= ADDR_W'(s * SEG_SIZE);
        end
        assign seg_lock[s] = (NW'(s) + nlock) >= NW'(NSEG);
    end

    // Purpose: locked when the address reaches the lowest locked segment.
    assign locked = |(above & seg_lock);

    AST_CODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bp == 2'b00) |-> !locked); // R7
    AST_CODE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bp == 2'b11) |-> locked); // R7
endmodule

// File: rtl/spi_wp_status.sv
// Module: top of the SPI write-protect status block.
// Connects the frame collector, the decoder and status register, and the
// address comparator. The serial data-out is never driven by this block.
// Assumes SPI mode 0 and inputs synchronous to clk.
module spi_wp_status #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              addr_locked,
    output logic              hw_lock,
    output logic [7:0]        status
);
    localparam int unsigned FRAME_W = 16;
    localparam int unsigned CNT_W   = $clog2(FRAME_W) + 1;
    localparam int unsigned NSEG    = 4;

    logic               frame_end;
    logic [CNT_W-1:0]   frame_cnt;
    logic [FRAME_W-1:0] frame_bits;
    logic [1:0]         bp;

    // Purpose: data-out stays high-impedance for every supported frame.
    assign spi_miso    = 1'b0;
    assign spi_miso_oe = 1'b0;

    spi_wp_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (spi_cs_n),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .frame_end  (frame_end),
        .frame_cnt  (frame_cnt),
        .frame_bits (frame_bits)
    );

    spi_wp_cmd #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .frame_cnt  (frame_cnt),
        .frame_bits (frame_bits),
        .wp_n       (wp_n),
        .bp         (bp),
        .hw_lock    (hw_lock),
        .status     (status)
    );

    spi_wp_range #(.ADDR_W(ADDR_W), .NSEG(NSEG)) u_range (
        .clk    (clk),
        .rst_n  (rst_n),
        .bp     (bp),
        .addr   (addr),
        .locked (addr_locked)
    );

    AST_LOCK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        wp_n |-> !hw_lock); // R6
endmodule

// File: tb/spi_wp_status_test.sv
module spi_wp_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // Vector fields: {wren_first, wp_n, nbits[4:0], frame[19:0], exp_status[7:0]}
    localparam logic [34:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 5'd16, 20'h0018C, 8'h00}, // R3 no latch
        {1'b1, 1'b1, 5'd16, 20'h0018C, 8'h8C}, // R2 load
        {1'b1, 1'b0, 5'd16, 20'h00104, 8'h8C}, // R6 R5 frozen, latch cleared
        {1'b1, 1'b1, 5'd16, 20'h00104, 8'h04}, // R2 pin high unlocks
        {1'b1, 1'b1, 5'd15, 20'h00084, 8'h06}, // R4 short frame
        {1'b0, 1'b1, 5'd17, 20'h00210, 8'h06}, // R4 long frame
        {1'b0, 1'b1, 5'd16, 20'h00108, 8'h08}, // R5 latch kept, then cleared
        {1'b1, 1'b1, 5'd8,  20'h00004, 8'h08}, // R1 clear latch
        {1'b0, 1'b1, 5'd8,  20'h00006, 8'h0A}, // R1 set latch
        {1'b0, 1'b0, 5'd16, 20'h001FF, 8'h8C}, // R2 R6 ignored bits, no lock yet
        {1'b1, 1'b0, 5'd16, 20'h00100, 8'h8C}, // R6 frozen
        {1'b1, 1'b1, 5'd16, 20'h00100, 8'h00}  // R6 unlocked
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic        wp_n = 1'b1;
    logic [11:0] addr = '0;
    logic        addr_locked;
    logic        hw_lock;
    logic [7:0]  status;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_wp_status uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .wp_n        (wp_n),
        .addr        (addr),
        .addr_locked (addr_locked),
        .hw_lock     (hw_lock),
        .status      (status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [19:0] w, input int n);
        @(negedge clk) spi_cs_n = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) begin spi_mosi = w[i]; spi_sck = 1'b0; end
            @(negedge clk) spi_sck = 1'b1;
        end
        @(negedge clk) spi_sck = 1'b0;
        @(negedge clk) spi_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_bp(input logic [1:0] code);
        wp_n = 1'b1;
        send_frame(20'h00006, 8);
        send_frame({12'h001, 4'h0, code, 2'b00}, 16);
    endtask

    function automatic bit exp_lock(input logic [1:0] code, input logic [11:0] a);
        case (code)
            2'b00:   return 1'b0;
            2'b01:   return a >= 12'hC00;
            2'b10:   return a >= 12'h800;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 8'h00, "R9 reset status", status, 8'h00);
        check(spi_miso_oe == 1'b0, "R8 miso idle", spi_miso_oe, 0);

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [34:0] e;
            e = VECS[v];
            wp_n = e[33];
            if (e[34]) send_frame(20'h00006, 8);
            send_frame(e[27:8], int'(e[32:28]));
            check(status == e[7:0], $sformatf("R2/R6 vector %0d status", v), status, e[7:0]);
            check(status[0] == 1'b0, "R8 busy bit", status[0], 0);
            check(hw_lock == (!wp_n && status[7]), "R6 lock flag", hw_lock, !wp_n && status[7]);
        end

        // R8: the data-out enable is watched across a whole status write
        wp_n = 1'b1;
        send_frame(20'h00006, 8);
        @(negedge clk) spi_cs_n = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk) begin spi_mosi = (i == 8); spi_sck = 1'b0; end
            check(spi_miso_oe == 1'b0, "R8 miso during frame", spi_miso_oe, 0);
            @(negedge clk) spi_sck = 1'b1;
        end
        @(negedge clk) spi_sck = 1'b0;
        @(negedge clk) spi_cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check(status == 8'h00, "R8 status after watched frame", status, 8'h00);

        // R7: boundary sweep under each block-protect code
        for (int c = 0; c < 4; c++) begin
            set_bp(2'(c));
            check(status[3:2] == 2'(c), "R7 code loaded", status[3:2], c);
            for (int k = 0; k < 8; k++) begin
                logic [11:0] a;
                a = (k[0] ? 12'(((k >> 1) + 1) * 12'h400 - 1) : 12'((k >> 1) * 12'h400));
                addr = a;
                #1;
                check(addr_locked == exp_lock(2'(c), a),
                      $sformatf("R7 code %0d addr 0x%0h", c, a), addr_locked, exp_lock(2'(c), a));
            end
        end

        // R10: stray SPI clocks with chip-select high, then a clean set-latch frame
        set_bp(2'b00);
        repeat (5) begin
            @(negedge clk) spi_sck = 1'b1;
            @(negedge clk) spi_sck = 1'b0;
        end
        send_frame(20'h00006, 8);
        check(status == 8'h02, "R10 count restarts", status, 8'h02);
        send_frame(20'h00006, 7);
        send_frame(20'h00004, 8);
        check(status == 8'h00, "R10 R1 clear after short frame", status, 8'h00);

        // R9: reset in mid-run clears loaded bits and the latch
        set_bp(2'b11);
        send_frame(20'h00006, 8);
        check(status == 8'h0E, "R9 pre-reset state", status, 8'h0E);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 8'h00, "R9 mid-run reset", status, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule